// File: doc/BRIEF.md
# Match-Set / Wrap-Clear PWM Generator

This block produces a fixed-frequency pulse-width-modulated output. A free-running W-bit phase counter cycles through 2^W states. Its value is compared for exact equality with a shadow copy of the duty word. A match sets a clocked set/reset flag, and the wrap of the counter clears that flag. The flag drives the PWM output directly.

The duty word on the input pins is sampled into the shadow copy only in the counter's last state. A new value therefore takes effect at the start of the next period and never disturbs the period in progress. A one-cycle strobe marks that last state, so a controller can change the duty word in step with period boundaries. The duty word is a plain control input with no handshake: whatever value is present in the strobe cycle is the one taken.

Top module: `pwm_match_latch`

## Requirements
- R1: The phase counter starts at 0 after reset and counts up by one every clock, wrapping from 2^W-1 to 0. `wrap_o` is high exactly in the cycle where the counter holds 2^W-1, for one cycle in every 2^W.
- R2: With a loaded duty value D, `pwm_o` is high in period phases D+1 through 2^W-1 (phase 0 is the cycle after `wrap_o`). This gives 2^W-1-D high cycles per period, and the output is low in phase 0.
- R3: A loaded duty value of all ones (2^W-1) keeps `pwm_o` low for the whole period, because the clear from the wrap overrides the set from the match.
- R4: `duty_i` is sampled only on the clock edge at the end of the cycle where `wrap_o` is high. Changes at any other time have no effect on the current period or on the next one.
- R5: A synchronous reset (`rst_i` high at a clock edge) forces the counter to 0, the shadow duty to 0 and `pwm_o` low. The first period after reset therefore behaves as duty 0.
- R6: A loaded duty value of 0 gives 2^W-1 high cycles: low only in phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| duty_i | input | W | Duty word, sampled in the wrap cycle |
| pwm_o | output | 1 | PWM output |
| wrap_o | output | 1 | High in the last cycle of each period |

## Verification
The hardest situation to reach from the ports is a duty change that could leak into a period through the shadow register. The stimulus applies one duty value during the first half of each period and a different one during the second half, so only the value present in the wrap cycle may show up in the next period's pulse. The extreme values, all ones and zero, are placed back to back, so the case where set and clear meet in the same cycle is exercised right after a period that was high almost throughout. A reset applied in the middle of a period checks that the output restarts as the duty-0 case.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_W_DEFAULT = 8;

  typedef struct packed {
    logic set;
    logic clr;
  } sr_ctl_t;
endpackage

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == TOP);
endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       q_q <= '0;
    else if (load_i) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pwm_sr_flag.sv
module pwm_sr_flag
  import pwm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  sr_ctl_t ctl_i,
  output logic    q_o
);
  logic q_q;

  // clear has priority over set
  always_ff @(posedge clk_i) begin
    if (rst_i)          q_q <= 1'b0;
    else if (ctl_i.clr) q_q <= 1'b0;
    else if (ctl_i.set) q_q <= 1'b1;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pwm_match_latch.sv
module pwm_match_latch
  import pwm_pkg::*;
#(
  parameter int unsigned W = PWM_W_DEFAULT
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] duty_q;
  logic         last;
  sr_ctl_t      ctl;

  pwm_phase_counter #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cnt_o  (cnt_q),
    .last_o (last)
  );

  pwm_duty_shadow #(.W(W)) u_shadow (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (last),
    .d_i    (duty_i),
    .q_o    (duty_q)
  );

  always_comb begin
    ctl.set = (cnt_q == duty_q);
    ctl.clr = last;
  end

  pwm_sr_flag u_flag (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .ctl_i (ctl),
    .q_o   (pwm_o)
  );

  assign wrap_o = last;
endmodule

// File: rtl/pwm_match_latch_chk.sv
module pwm_match_latch_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         pwm_o,
  input logic         wrap_o,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] duty_q
);
  // R1: counter restarts at zero after the wrap cycle
  p_restart_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> (cnt_q == '0));

  // R1: strobe lasts a single cycle
  p_single_wrap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> !wrap_o);

  // R2: output is low in phase 0
  p_low_after_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> !pwm_o);

  // R2: output rises only after an equality match
  p_rise_on_match_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pwm_o) |-> ($past(cnt_q) == $past(duty_q)));

  // R3: an all-ones duty keeps the output low
  p_full_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (&duty_q) |-> !pwm_o);

  // R4: shadow duty moves only after a wrap cycle
  p_duty_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_o |=> $stable(duty_q));

  // R5: reset clears counter, shadow and output
  p_reset_clear_r5: assert property (@(posedge clk_i)
    rst_i |=> (!pwm_o && cnt_q == '0 && duty_q == '0));
endmodule

bind pwm_match_latch pwm_match_latch_chk #(.W(W)) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .pwm_o  (pwm_o),
  .wrap_o (wrap_o),
  .cnt_q  (cnt_q),
  .duty_q (duty_q)
);

// File: tb/pwm_match_latch_tb_top.sv
module pwm_match_latch_tb_top;
  localparam int W   = 8;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] duty = '0;
  logic         pwm;
  logic         wrap;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  int phase  = 0;
  int d_cur  = 0;
  int hi_cnt = 0;
  bit full   = 0;   // current period started cleanly at phase 0
  bit r4_per = 0;   // current period follows a mid-period duty change

  always #5 clk = ~clk;

  pwm_match_latch #(.W(W)) dut_i (
    .clk_i  (clk),
    .rst_i  (rst),
    .duty_i (duty),
    .pwm_o  (pwm),
    .wrap_o (wrap)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s phase=%0d duty=%0d actual=%0d expected=%0d",
               tag, phase, d_cur, act, exp);
    end
  endtask

  function automatic string duty_tag(input int d);
    if (d == MAX) return "R3";
    if (d == 0)   return "R6";
    return "R2";
  endfunction

  // one cycle: compare at the negedge, drive, advance the model
  task automatic step(input logic [W-1:0] dv, input bit do_rst);
    string t;
    t = r4_per ? "R4" : duty_tag(d_cur);
    check("R1 wrap", int'(wrap), int'(phase == MAX));
    check(t, int'(pwm), int'(phase > d_cur));
    if (pwm) hi_cnt++;
    if (phase == MAX && full)
      check({t, " high-count"}, hi_cnt, MAX - d_cur);
    duty = dv;
    rst  = do_rst;
    if (do_rst) begin
      phase = 0; d_cur = 0; hi_cnt = 0; full = 1; r4_per = 0;
    end else if (phase == MAX) begin
      d_cur = int'(dv); phase = 0; hi_cnt = 0; full = 1; r4_per = 0;
    end else begin
      phase++;
    end
    @(negedge clk);
  endtask

  // a period with one value in its first half and another in its second
  task automatic period(input logic [W-1:0] early, input logic [W-1:0] late);
    bit chg;
    chg = (early != late);
    for (int p = 0; p <= MAX; p++) begin
      step((p < MAX/2) ? early : late, 1'b0);
    end
    if (chg) r4_per = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R5: outputs low while reset is held
    check("R5 reset pwm", int'(pwm), 0);
    check("R5 reset wrap", int'(wrap), 0);
    rst = 1'b0;
    phase = 0; d_cur = 0; full = 1;
    // first period after reset acts as duty 0 (R5)
    period(8'd200, 8'd64);
    period(8'd10,  8'd0);
    period(8'd0,   8'd255);
    period(8'd255, 8'd254);
    period(8'd254, 8'd128);
    period(8'd128, 8'd1);
    period(8'd77,  8'd77);
    // R5: reset in mid-period
    for (int i = 0; i < 50; i++) step(8'd40, 1'b0);
    step(8'd40, 1'b1);
    step(8'd40, 1'b1);
    check("R5 mid-reset pwm", int'(pwm), 0);
    period(8'd90, 8'd32);
    period(8'd32, 8'd32);
    period(8'd32, 8'd32);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule